// File: doc/BRIEF.md
# Weighted Slot-Table Round-Robin Arbiter

This block chooses which upstream port may issue on one address channel of a single downstream port. Arbitration runs over an ordered ring of slots. Each slot names one upstream port. A port that owns several slots receives a matching share of grants when every port is busy. A head pointer marks the slot with top priority. The search walks the ring from the head and stops at the first slot whose owner is requesting.

The decision is captured in a register, so the one-hot grant seen in a cycle reflects the requests of the cycle before. A grant to a requesting port moves the head to the slot just after the winner, which makes the winning slot the lowest in priority. When nobody requests, a fixed default port is granted and the head stays where it is. A quality-of-service filter can narrow the set of ports that may win. While the filter is on, the default grant is suppressed.

Slot ownership can be rewritten at run time through a single APB-style data word. A second command in the same word selects which slot a read returns.

Top module: `sarb_top`

## Requirements
- R1: After reset the grant is all zero, slot i is owned by port i mod NPORTS, and the head is slot 0.
- R2: The grant is registered: inputs sampled at a rising edge decide the grant seen after that edge, and the grant is one-hot or zero.
- R3: The winner is the owner of the first slot, searching from the head and wrapping, whose port is a candidate. Candidates are the requesting ports, further masked by elig_i while qos_on_i is high.
- R4: After a grant to a candidate from slot s, the head becomes slot s+1, wrapping to 0 after the last slot.
- R5: With qos_on_i low and no request, the grant is the one-hot of DEF_PORT and the head does not move.
- R6: With qos_on_i high, only ports whose elig_i bit is set can win. If none of them requests, the grant is all zero and the head does not move.
- R7: A write (psel_i, penable_i and pwrite_i high) with pwdata_i[31:24] equal to a slot number, pwdata_i[23:8] zero and pwdata_i[7:0] equal to a port number makes that port the owner of that slot.
- R8: A write with pwdata_i[31:24] equal to 0xFF selects the slot given in pwdata_i[7:0]. From then on prdata_o carries that slot's owner in bits [7:0], with all other bits zero (all zero for a slot number beyond the table).
- R9: A write naming a slot at or above NSLOTS, a port at or above NPORTS, or nonzero bits [23:8] leaves the table unchanged.
- R10: A table write is used by the first arbitration after the edge that stores it. An arbitration at that same edge still uses the old owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NPORTS | Request per upstream port |
| qos_on_i | input | 1 | Quality-of-service restriction active |
| elig_i | input | NPORTS | Ports allowed to win while the restriction is active |
| psel_i | input | 1 | Programming select |
| penable_i | input | 1 | Programming access phase |
| pwrite_i | input | 1 | Programming write |
| pwdata_i | input | 32 | Programming write word |
| prdata_o | output | 32 | Owner of the selected slot |
| grant_o | output | NPORTS | Registered one-hot grant |

## Verification
A table write and an arbitration can land on the same clock edge. This happens whenever a port requests during the access phase of a slot write. The bench provokes it by rewriting the owner of the slot at the head while the old owner and the new owner both request. It then checks that the grant registered at that edge goes to the old owner. The next arbitrations, and a read-back of the slot, must show the new owner.

// File: rtl/sarb_pkg.sv
package sarb_pkg;

    localparam logic [7:0] RDSEL_KEY = 8'hFF;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_SLOT,
        CMD_SELECT,
        CMD_DROP
    } cmd_e;

    function automatic cmd_e decode_cmd(input logic wr, input logic [31:0] word,
                                        input int nslots, input int nports);
        if (!wr) return CMD_IDLE;
        if (word[31:24] == RDSEL_KEY) return CMD_SELECT;
        if ((32'(word[31:24]) < nslots) && (32'(word[7:0]) < nports) && (word[23:8] == 16'h0))
            return CMD_SLOT;
        return CMD_DROP;
    endfunction

endpackage

// File: rtl/sarb_slot_table.sv
module sarb_slot_table #(
    parameter int NPORTS = 4,
    parameter int NSLOTS = 8,
    parameter int PW     = 2,
    parameter int SW     = 3
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         wr_i,
    input  logic [31:0]                  wdata_i,
    output logic [31:0]                  rdata_o,
    output logic [NSLOTS-1:0][PW-1:0]    owners_o
);
    import sarb_pkg::*;

    typedef struct packed {
        logic [NSLOTS-1:0][PW-1:0] owner;
        logic [7:0]                rsel;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    cmd_e cmd;

    always_comb begin
        tbl_d = tbl_q;
        cmd   = decode_cmd(wr_i, wdata_i, NSLOTS, NPORTS);
        case (cmd)
            CMD_SLOT:   tbl_d.owner[wdata_i[24 +: SW]] = wdata_i[PW-1:0];
            CMD_SELECT: tbl_d.rsel = wdata_i[7:0];
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NSLOTS; i++) tbl_q.owner[i] <= PW'(i % NPORTS);
            tbl_q.rsel <= 8'h00;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    always_comb begin
        rdata_o = 32'h0;
        if (32'(tbl_q.rsel) < NSLOTS) rdata_o[7:0] = 8'(tbl_q.owner[tbl_q.rsel[SW-1:0]]);
    end

    assign owners_o = tbl_q.owner;

    // R9: rejected writes leave every owner as it was
    a_r9_reject_keeps_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && wdata_i[31:24] != 8'hFF &&
         (32'(wdata_i[31:24]) >= NSLOTS || 32'(wdata_i[7:0]) >= NPORTS || wdata_i[23:8] != 16'h0))
        |=> $stable(owners_o));

    // R7: an accepted write is visible in the named slot after the edge
    a_r7_slot_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && 32'(wdata_i[31:24]) < NSLOTS && 32'(wdata_i[7:0]) < NPORTS && wdata_i[23:8] == 16'h0)
        |=> (owners_o[$past(wdata_i[24 +: SW])] == $past(wdata_i[PW-1:0])));

endmodule

// File: rtl/sarb_pick.sv
module sarb_pick #(
    parameter int NPORTS = 4,
    parameter int NSLOTS = 8,
    parameter int PW     = 2,
    parameter int SW     = 3
) (
    input  logic [NSLOTS-1:0][PW-1:0] owners_i,
    input  logic [SW-1:0]             head_i,
    input  logic [NPORTS-1:0]         cand_i,
    output logic                      hit_o,
    output logic [SW-1:0]             slot_o,
    output logic [PW-1:0]             port_o
);
    always_comb begin
        hit_o  = 1'b0;
        slot_o = '0;
        port_o = '0;
        for (int p = NSLOTS - 1; p >= 0; p--) begin
            logic [SW:0] pos;
            pos = {1'b0, head_i} + (SW+1)'(p);
            if (32'(pos) >= NSLOTS) pos = pos - (SW+1)'(NSLOTS);
            if (cand_i[owners_i[pos[SW-1:0]]]) begin
                hit_o  = 1'b1;
                slot_o = pos[SW-1:0];
                port_o = owners_i[pos[SW-1:0]];
            end
        end
    end
endmodule

// File: rtl/sarb_top.sv
module sarb_top #(
    parameter int NPORTS   = 4,
    parameter int NSLOTS   = 8,
    parameter int DEF_PORT = 0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NPORTS-1:0] req_i,
    input  logic              qos_on_i,
    input  logic [NPORTS-1:0] elig_i,
    input  logic              psel_i,
    input  logic              penable_i,
    input  logic              pwrite_i,
    input  logic [31:0]       pwdata_i,
    output logic [31:0]       prdata_o,
    output logic [NPORTS-1:0] grant_o
);
    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
    localparam int SW = $clog2(NSLOTS);
    localparam logic [NPORTS-1:0] DEF_GRANT = NPORTS'(1) << DEF_PORT;

    typedef struct packed {
        logic [NPORTS-1:0] grant;
        logic [SW-1:0]     head;
    } arb_t;

    arb_t arb_d, arb_q;

    logic [NSLOTS-1:0][PW-1:0] owners;
    logic [NPORTS-1:0]         cand;
    logic                      hit;
    logic [SW-1:0]             win_slot;
    logic [PW-1:0]             win_port;
    logic                      wr;

    assign wr = psel_i & penable_i & pwrite_i;

    sarb_slot_table #(.NPORTS(NPORTS), .NSLOTS(NSLOTS), .PW(PW), .SW(SW)) u_table (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (wr),
        .wdata_i  (pwdata_i),
        .rdata_o  (prdata_o),
        .owners_o (owners)
    );

    assign cand = qos_on_i ? (req_i & elig_i) : req_i;

    sarb_pick #(.NPORTS(NPORTS), .NSLOTS(NSLOTS), .PW(PW), .SW(SW)) u_pick (
        .owners_i (owners),
        .head_i   (arb_q.head),
        .cand_i   (cand),
        .hit_o    (hit),
        .slot_o   (win_slot),
        .port_o   (win_port)
    );

    always_comb begin
        arb_d = arb_q;
        if (hit) begin
            arb_d.grant = NPORTS'(1) << win_port;
            arb_d.head  = (32'(win_slot) == NSLOTS - 1) ? '0 : win_slot + SW'(1);
        end else if (!qos_on_i) begin
            arb_d.grant = DEF_GRANT;
        end else begin
            arb_d.grant = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) arb_q <= '0;
        else         arb_q <= arb_d;
    end

    assign grant_o = arb_q.grant;

    // R2: never more than one port granted
    a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(grant_o));

    // R3: any candidate present means a candidate is granted next cycle
    a_r3_grant_is_candidate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cand != '0) |=> ((grant_o & $past(cand)) != '0));

    // R5: idle without restriction gives the default port and keeps the head
    a_r5_default_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!qos_on_i && req_i == '0) |=> (grant_o == DEF_GRANT) && $stable(arb_q.head));

    // R6: restriction with no eligible requester grants nobody
    a_r6_qos_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (qos_on_i && (req_i & elig_i) == '0) |=> (grant_o == '0) && $stable(arb_q.head));

    // R6: restricted grants go only to eligible ports
    a_r6_only_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (qos_on_i) |=> ((grant_o & ~$past(elig_i)) == '0));

endmodule

// File: tb/sarb_top_bench.sv
module sarb_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req = '0;
    logic        qos = 1'b0;
    logic [3:0]  elig = '0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [3:0]  grant;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sarb_top u_sarb_top (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .qos_on_i(qos), .elig_i(elig),
        .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite), .pwdata_i(pwdata),
        .prdata_o(prdata), .grant_o(grant)
    );

    // {qos, elig, req, expected grant}; default table owners 0,1,2,3,0,1,2,3
    localparam logic [12:0] VEC [12] = '{
        {1'b0, 4'b0000, 4'b0000, 4'b0001},  // R5 idle default, head 0
        {1'b0, 4'b0000, 4'b1111, 4'b0001},  // R3 slot0 wins, head 1
        {1'b0, 4'b0000, 4'b1111, 4'b0010},  // R4 slot1 wins, head 2
        {1'b0, 4'b0000, 4'b1000, 4'b1000},  // slot3 wins, head 4
        {1'b0, 4'b0000, 4'b1000, 4'b1000},  // slot7 wins, head wraps 0
        {1'b0, 4'b0000, 4'b0110, 4'b0010},  // slot1, head 2
        {1'b0, 4'b0000, 4'b0110, 4'b0100},  // slot2, head 3
        {1'b1, 4'b0001, 4'b0110, 4'b0000},  // R6 none eligible
        {1'b1, 4'b0100, 4'b0110, 4'b0100},  // R6 slot6, head 7
        {1'b0, 4'b0000, 4'b0000, 4'b0001},  // R5 default, head stays 7
        {1'b0, 4'b0000, 4'b1001, 4'b1000},  // slot7, head 0
        {1'b0, 4'b0000, 4'b1001, 4'b0001}   // slot0, head 1
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // setup phase with no request, access phase with reqv; returns at the negedge after the write edge
    task automatic apb_wr(input logic [31:0] data, input logic [3:0] reqv);
        req = 4'b0; psel = 1'b1; penable = 1'b0; pwrite = 1'b1; pwdata = data;
        @(posedge clk); @(negedge clk);
        penable = 1'b1; req = reqv;
        @(posedge clk); @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; req = 4'b0;
    endtask

    task automatic step(input logic [3:0] reqv);
        req = reqv;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 grant in reset", 32'(grant), 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            {qos, elig, req} = VEC[i][12:4];
            @(posedge clk); @(negedge clk);
            chk((i == 0 || i == 9) ? "R5 default" : (i == 7 || i == 8) ? "R6 qos" : "R2 R3 R4 rotate",
                32'(grant), 32'(VEC[i][3:0]));
        end
        qos = 1'b0; elig = '0; req = '0;

        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 grant after reset", 32'(grant), 32'h0);
        rst_n = 1'b1;
        apb_wr(32'hFF00_0003, 4'b0);
        chk("R8 R1 read slot3", prdata, 32'h3);
        apb_wr(32'hFF00_0005, 4'b0);
        chk("R1 read slot5", prdata, 32'h1);
        apb_wr(32'h0500_0003, 4'b0);
        chk("R7 write slot5", prdata, 32'h3);
        apb_wr(32'h0800_0002, 4'b0);
        apb_wr(32'hFF00_0000, 4'b0);
        chk("R9 slot beyond table", prdata, 32'h0);
        apb_wr(32'h0200_0007, 4'b0);
        apb_wr(32'hFF00_0002, 4'b0);
        chk("R9 port beyond range", prdata, 32'h2);
        apb_wr(32'h0200_0101, 4'b0);
        chk("R9 nonzero middle bits", prdata, 32'h2);

        apb_wr(32'h0000_0002, 4'b0);
        chk("R5 idle during write", 32'(grant), 32'h1);
        step(4'b0101);
        chk("R10 new owner used next", 32'(grant), 32'h4);
        apb_wr(32'h0100_0000, 4'b0011);
        chk("R10 same edge uses old owner", 32'(grant), 32'h2);
        step(4'b0000);
        chk("R5 head kept", 32'(grant), 32'h1);
        step(4'b0001);
        chk("R4 head after slot1", 32'(grant), 32'h1);
        apb_wr(32'hFF00_0001, 4'b0);
        chk("R8 readback rewritten slot1", prdata, 32'h0);
        apb_wr(32'hFF00_0009, 4'b0);
        chk("R8 select beyond table", prdata, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule